// File: doc/BRIEF.md
# Channel Command Decoder

This block turns single-byte command writes into the control state of a serial channel. Each byte carries three independent fields: a receiver command, a transmitter command and a miscellaneous action code. The receiver and transmitter commands move persistent enable levels. The action code produces a one-clock pulse toward the rest of the channel. The pulses reset the mode-register pointer, reset the receiver or transmitter together with its FIFO, clear the error flags, or clear the break-change flag.

One instance serves `NUM_CH` channels, two by default. Each write names the channel it addresses, and the other channels are left alone. The block also holds each channel's break-change interrupt bit. Channel c places that bit at position 4*c+2 of an interrupt-status view, so a clear command can be observed at the ports.

Writes arrive on a valid/ready interface. `cmd_ready` is always high because the decoder has no storage to fill, so it never applies back-pressure. A write takes place on every rising edge at which `cmd_valid` is high. A source may issue one write on every cycle.

Top module: `ccr_cmd_decoder`

## Requirements
- R1: `cmd_ready` is always 1. A write is accepted at each rising edge where `cmd_valid` is 1. With `cmd_valid` at 0, the enables, pulses and break bits are not affected by `cmd_chan` or `cmd_data`.
- R2: Receiver field `cmd_data[1:0]` acts on the addressed channel's `rx_enable` from the write edge onward: 01 sets it to 1, 10 sets it to 0, and 00 holds it.
- R3: Transmitter field `cmd_data[3:2]` acts on the addressed channel's `tx_enable` with the same codes: 01 sets it to 1, 10 sets it to 0, and 00 holds it.
- R4: Code 11 in either enable field leaves that enable unchanged.
- R5: Action field `cmd_data[7:4]` sets a pulse on the addressed channel's bit: 0001 `ptr_rst_pulse`, 0010 `rx_rst_pulse`, 0011 `tx_rst_pulse`, 0100 `err_clr_pulse`, 0101 `brk_clr_pulse`. The pulse is high for exactly the cycle after the write edge, and no other channel pulses.
- R6: Action 0010 forces that channel's `rx_enable` to 0, and 0011 forces its `tx_enable` to 0. This holds even when the same byte enables that side.
- R7: Action codes 0000 and 0110 through 1111 raise no pulse.
- R8: All three fields of one byte take effect at the same write edge.
- R9: A high `brk_chg_set[c]` at an edge sets `isr_brk` bit 4*c+2. A write with action 0101 to channel c clears that bit at the write edge. If the set and the clear arrive in the same cycle, the set wins. All other `isr_brk` bits read 0.
- R10: During and after reset, all enables, pulses and break bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte present |
| cmd_ready | output | 1 | Always 1; the decoder never stalls |
| cmd_chan | input | CH_W | Channel addressed by the write |
| cmd_data | input | 8 | Command byte |
| brk_chg_set | input | NUM_CH | Break-change event per channel |
| rx_enable | output | NUM_CH | Receiver enable level per channel |
| tx_enable | output | NUM_CH | Transmitter enable level per channel |
| ptr_rst_pulse | output | NUM_CH | Reset mode-register pointer |
| rx_rst_pulse | output | NUM_CH | Reset receiver and flush its FIFO |
| tx_rst_pulse | output | NUM_CH | Reset transmitter and flush its FIFO |
| err_clr_pulse | output | NUM_CH | Clear break, parity and overrun flags |
| brk_clr_pulse | output | NUM_CH | Clear break-change flag |
| isr_brk | output | 4*NUM_CH | Interrupt-status view holding the break-change bits |

## Verification
A wrong enable state shows on `rx_enable` or `tx_enable` in the cycle after the faulty write, and it stays wrong until another write corrects it. A mis-decoded action shows as a missing or extra pulse in that same cycle, or on the wrong channel's bit. A pulse that lasts too long shows one cycle later. A broken break-bit path shows on `isr_brk` one cycle after the set or clear.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int BYTE_W = 8;
  localparam int ACT_W  = 5;

  localparam logic [1:0] EN_HOLD = 2'b00;
  localparam logic [1:0] EN_ON   = 2'b01;
  localparam logic [1:0] EN_OFF  = 2'b10;

  localparam logic [3:0] ACT_PTR_RST = 4'h1;
  localparam logic [3:0] ACT_RX_RST  = 4'h2;
  localparam logic [3:0] ACT_TX_RST  = 4'h3;
  localparam logic [3:0] ACT_ERR_CLR = 4'h4;
  localparam logic [3:0] ACT_BRK_CLR = 4'h5;

  localparam int P_PTR = 0;
  localparam int P_RXR = 1;
  localparam int P_TXR = 2;
  localparam int P_ERR = 3;
  localparam int P_BRK = 4;

  typedef struct packed {
    logic             rx_on;
    logic             rx_off;
    logic             tx_on;
    logic             tx_off;
    logic [ACT_W-1:0] act;
  } cmd_dec_t;
endpackage

// File: rtl/ccr_field_decode.sv
module ccr_field_decode
  import ccr_pkg::*;
(
  input  logic [BYTE_W-1:0] cmd_byte,
  output cmd_dec_t          dec
);
  logic [1:0] rx_f, tx_f;
  logic [3:0] act_f;

  assign rx_f  = cmd_byte[1:0];
  assign tx_f  = cmd_byte[3:2];
  assign act_f = cmd_byte[7:4];

  always_comb begin
    dec        = '0;
    dec.rx_on  = (rx_f == EN_ON);
    dec.rx_off = (rx_f == EN_OFF);
    dec.tx_on  = (tx_f == EN_ON);
    dec.tx_off = (tx_f == EN_OFF);
    unique case (act_f)
      ACT_PTR_RST: dec.act[P_PTR] = 1'b1;
      ACT_RX_RST:  dec.act[P_RXR] = 1'b1;
      ACT_TX_RST:  dec.act[P_TXR] = 1'b1;
      ACT_ERR_CLR: dec.act[P_ERR] = 1'b1;
      ACT_BRK_CLR: dec.act[P_BRK] = 1'b1;
      default:     dec.act        = '0;
    endcase
  end
endmodule

// File: rtl/ccr_enable_ctl.sv
module ccr_enable_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic on,
  input  logic off,
  input  logic force_off,
  output logic en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 en <= 1'b0;
    else if (wr && force_off)   en <= 1'b0;
    else if (wr && on)          en <= 1'b1;
    else if (wr && off)         en <= 1'b0;
  end

  assert_reset_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && force_off) |=> !en);
  assert_enable_set_R2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && on && !force_off) |=> en);
  assert_idle_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr) |=> $stable(en));
endmodule

// File: rtl/ccr_pulse_gen.sv
module ccr_pulse_gen
  import ccr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [ACT_W-1:0] act,
  output logic [ACT_W-1:0] pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= '0;
    else        pulse <= wr ? act : '0;
  end

  assert_pulse_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulse));
  assert_pulse_has_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse != '0) |-> $past(wr));
  assert_pulse_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && act[P_RXR]) |=> pulse[P_RXR]);
endmodule

// File: rtl/ccr_brk_latch.sv
module ccr_brk_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assert_brk_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
  assert_brk_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);
endmodule

// File: rtl/ccr_cmd_decoder.sv
module ccr_cmd_decoder
  import ccr_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ISR_W = 4 * NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CH_W-1:0]   cmd_chan,
  input  logic [BYTE_W-1:0] cmd_data,
  input  logic [NUM_CH-1:0] brk_chg_set,
  output logic [NUM_CH-1:0] rx_enable,
  output logic [NUM_CH-1:0] tx_enable,
  output logic [NUM_CH-1:0] ptr_rst_pulse,
  output logic [NUM_CH-1:0] rx_rst_pulse,
  output logic [NUM_CH-1:0] tx_rst_pulse,
  output logic [NUM_CH-1:0] err_clr_pulse,
  output logic [NUM_CH-1:0] brk_clr_pulse,
  output logic [ISR_W-1:0]  isr_brk
);
  cmd_dec_t dec;
  logic [NUM_CH-1:0] brk_q;

  assign cmd_ready = 1'b1;

  ccr_field_decode u_dec (
    .cmd_byte (cmd_data),
    .dec      (dec)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic             wr_c;
    logic [ACT_W-1:0] pls;

    assign wr_c = cmd_valid && (cmd_chan == CH_W'(c));

    ccr_enable_ctl u_rx_en (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (wr_c),
      .on        (dec.rx_on),
      .off       (dec.rx_off),
      .force_off (dec.act[P_RXR]),
      .en        (rx_enable[c])
    );

    ccr_enable_ctl u_tx_en (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (wr_c),
      .on        (dec.tx_on),
      .off       (dec.tx_off),
      .force_off (dec.act[P_TXR]),
      .en        (tx_enable[c])
    );

    ccr_pulse_gen u_pls (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_c),
      .act   (dec.act),
      .pulse (pls)
    );

    assign ptr_rst_pulse[c] = pls[P_PTR];
    assign rx_rst_pulse[c]  = pls[P_RXR];
    assign tx_rst_pulse[c]  = pls[P_TXR];
    assign err_clr_pulse[c] = pls[P_ERR];
    assign brk_clr_pulse[c] = pls[P_BRK];

    ccr_brk_latch u_brk (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (brk_chg_set[c]),
      .clr   (wr_c && dec.act[P_BRK]),
      .flag  (brk_q[c])
    );
  end

  always_comb begin
    isr_brk = '0;
    for (int c = 0; c < NUM_CH; c++) isr_brk[4*c+2] = brk_q[c];
  end

  assert_other_chan_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_chan == '0) |=> (rx_rst_pulse[NUM_CH-1:1] == '0 || NUM_CH == 1));
  assert_ready_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready);
endmodule

// File: tb/tb_ccr_cmd_decoder.sv
module tb_ccr_cmd_decoder;
  localparam int NUM_CH = 2;
  localparam int NV = 13;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [0:0] cmd_chan = '0;
  logic [7:0] cmd_data = '0;
  logic [1:0] brk_chg_set = '0;
  logic [1:0] rx_enable, tx_enable;
  logic [1:0] ptr_rst_pulse, rx_rst_pulse, tx_rst_pulse, err_clr_pulse, brk_clr_pulse;
  logic [7:0] isr_brk;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  ccr_cmd_decoder #(.NUM_CH(NUM_CH)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_chan      (cmd_chan),
    .cmd_data      (cmd_data),
    .brk_chg_set   (brk_chg_set),
    .rx_enable     (rx_enable),
    .tx_enable     (tx_enable),
    .ptr_rst_pulse (ptr_rst_pulse),
    .rx_rst_pulse  (rx_rst_pulse),
    .tx_rst_pulse  (tx_rst_pulse),
    .err_clr_pulse (err_clr_pulse),
    .brk_clr_pulse (brk_clr_pulse),
    .isr_brk       (isr_brk)
  );

  // {chan, byte, exp rx, exp tx, exp pulses {ptr,rxr,txr,err,brk}}
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 8'h01, 2'b01, 2'b00, 10'b00_00_00_00_00}, // R2 enable rx ch0
    {1'b0, 8'h04, 2'b01, 2'b01, 10'b00_00_00_00_00}, // R3 enable tx ch0
    {1'b1, 8'h05, 2'b11, 2'b11, 10'b00_00_00_00_00}, // R8 both on ch1
    {1'b0, 8'h0F, 2'b11, 2'b11, 10'b00_00_00_00_00}, // R4 code 11 holds
    {1'b0, 8'h02, 2'b10, 2'b11, 10'b00_00_00_00_00}, // R2 disable rx ch0
    {1'b0, 8'h10, 2'b10, 2'b11, 10'b01_00_00_00_00}, // R5 pointer reset
    {1'b1, 8'h21, 2'b00, 2'b11, 10'b00_10_00_00_00}, // R6 reset beats enable
    {1'b1, 8'h34, 2'b00, 2'b01, 10'b00_00_10_00_00}, // R6 tx reset beats enable
    {1'b0, 8'h48, 2'b00, 2'b00, 10'b00_00_00_01_00}, // R8 tx off + err clear
    {1'b1, 8'h55, 2'b10, 2'b10, 10'b00_00_00_00_10}, // R8 enables + brk clear
    {1'b0, 8'h60, 2'b10, 2'b10, 10'b00_00_00_00_00}, // R7 ignored code
    {1'b1, 8'hF0, 2'b10, 2'b10, 10'b00_00_00_00_00}, // R7 ignored code
    {1'b0, 8'h00, 2'b10, 2'b10, 10'b00_00_00_00_00}  // R7 no command
  };

  function automatic logic [9:0] pulses();
    return {ptr_rst_pulse, rx_rst_pulse, tx_rst_pulse, err_clr_pulse, brk_clr_pulse};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic ch, input logic [7:0] d);
    cmd_valid = 1'b1; cmd_chan = ch; cmd_data = d;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 rx reset", 32'(rx_enable), 0);
    chk("R10 tx reset", 32'(tx_enable), 0);
    chk("R10 pulses reset", 32'(pulses()), 0);
    chk("R10 isr reset", 32'(isr_brk), 0);
    chk("R1 ready", 32'(cmd_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][22], VEC[i][21:14]);
      chk($sformatf("R2 rx vec%0d", i), 32'(rx_enable), 32'(VEC[i][13:12]));
      chk($sformatf("R3 tx vec%0d", i), 32'(tx_enable), 32'(VEC[i][11:10]));
      chk($sformatf("R5 pulses vec%0d", i), 32'(pulses()), 32'(VEC[i][9:0]));
      @(negedge clk);
      chk($sformatf("R5 one-cycle vec%0d", i), 32'(pulses()), 0);
    end

    // R1: no write while valid low
    cmd_chan = 1'b1; cmd_data = 8'h2A;
    repeat (2) @(negedge clk);
    chk("R1 idle rx", 32'(rx_enable), 32'(2'b10));
    chk("R1 idle tx", 32'(tx_enable), 32'(2'b10));
    chk("R1 idle pulses", 32'(pulses()), 0);

    // R9 break bits
    brk_chg_set = 2'b01; @(negedge clk); brk_chg_set = 2'b00;
    chk("R9 ch0 set", 32'(isr_brk), 32'h04);
    brk_chg_set = 2'b10; @(negedge clk); brk_chg_set = 2'b00;
    chk("R9 ch1 set", 32'(isr_brk), 32'h44);
    wr(1'b0, 8'h50);
    chk("R9 ch0 clear", 32'(isr_brk), 32'h40);
    brk_chg_set = 2'b10;
    wr(1'b1, 8'h50);
    brk_chg_set = 2'b00;
    chk("R9 set wins", 32'(isr_brk), 32'h40);
    chk("R5 brk pulse ch1", 32'(brk_clr_pulse), 32'(2'b10));
    wr(1'b1, 8'h50);
    chk("R9 ch1 clear", 32'(isr_brk), 32'h00);

    // R6 on ch0 with rx enable and tx reset in one byte
    wr(1'b0, 8'h35);
    chk("R6 rx on", 32'(rx_enable), 32'(2'b11));
    chk("R6 tx forced off", 32'(tx_enable), 32'(2'b10));

    // R10 reset mid-run
    brk_chg_set = 2'b11; @(negedge clk); brk_chg_set = 2'b00;
    rst_n = 1'b0; @(negedge clk);
    chk("R10 rx after reset", 32'(rx_enable), 0);
    chk("R10 tx after reset", 32'(tx_enable), 0);
    chk("R10 isr after reset", 32'(isr_brk), 0);
    rst_n = 1'b1; @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule